// File: doc/BRIEF.md
# Sampled Tamper Event Monitor

This block watches one external tamper or event line and turns a qualified high level into a sticky event flag. The line can be watched on every tick of a slow reference clock, or only during short windows at a low repetition rate, so that an external pull-up draws current only while the line is actually being read. In the windowed modes a time filter can demand that the line stays high for a chosen number of consecutive ticks before the event counts, which rejects switch bounce.

Once qualified, the event latches a status flag. That flag drives an active-low detect output and an optional request to freeze the time counter. Only a host clear strobe removes the flag. While the system runs from backup power, the detect output can be forced inactive. The analog pull-up is outside the block. The block only tells it when to switch on.

The reference clock `clk` is assumed to run at `TICK_HZ` (1024 Hz by default). All windows and filter times are counted in ticks of this clock.

Top module: `event_watch`

## Requirements
- R1: `rate` selects how the line is watched. 0 means every tick. 1 means one window every TICK_HZ/2 ticks (2 Hz). 2 means one window every TICK_HZ ticks (1 Hz). 3 means one window every 4*TICK_HZ ticks (1/4 Hz). Counting starts with the first tick in which `en` is 1. The tick with index m after enable has window phase m mod period.
- R2: In a windowed mode, `filt` sets how many consecutive ticks the line must be high. 0 means 1 tick, 1 means 4, 2 means 16 and 3 means 32. These ticks start at phase 8 of the window. The event is taken only when the line was high (after the 2-flop synchroniser, i.e. driven 2 ticks earlier) on every one of those ticks. A high that ends before the run is complete gives no event, and so does a high outside the evaluation ticks.
- R3: When `rate` is 0, any synchronised high tick while enabled is an event and `filt` has no effect. The flag is visible 3 ticks after the line is driven high.
- R4: An event sets `ev_flag` to 1 on the next tick. The flag stays 1 until it is cleared. Out of reset `ev_flag` is 0, `det_n` is 1 and `halt_req` is 0.
- R5: A 1 on `clr` clears `ev_flag` on the next tick unless an event occurs in the same tick. No input can set the flag except a qualified event.
- R6: While `en` is 0, no event is taken and `pu_en` is 0.
- R7: `det_n` is 0 exactly when `ev_flag` is 1, except that it is held at 1 while both `on_batt` and `bat_dis` are 1.
- R8: `pu_en` is 0 whenever `pu_off` is 1. Otherwise, while enabled, it is 1 permanently in every-tick mode. In the windowed modes it is 1 for window phases below max(15, 8 + filter ticks).
- R9: `halt_req` is 1 exactly when `ev_flag` is 1 and `halt_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Monitor enable |
| rate | input | 2 | Watch-rate code |
| filt | input | 2 | Stability filter code |
| pu_off | input | 1 | Keep the pull-up off |
| bat_dis | input | 1 | Silence detect output on backup power |
| halt_en | input | 1 | Allow time-counter halt request |
| on_batt | input | 1 | Running from backup power |
| clr | input | 1 | Host clear strobe for the event flag |
| ev_in | input | 1 | External event line (asynchronous) |
| pu_en | output | 1 | Pull-up switch enable |
| det_n | output | 1 | Active-low event detect |
| halt_req | output | 1 | Request to freeze the time counter |
| ev_flag | output | 1 | Sticky event status |

## Verification
On every tick, the assertions check the following:
- the flag stays set until it is cleared;
- no flag appears while the monitor is disabled;
- a clear with the monitor disabled works;
- the detect output is silent on backup power when asked to be;
- the pull-up stays off when disabled;
- in windowed modes, the flag rises only right after the last evaluation tick of a window.

Whether a given input pattern should have produced an event cannot be stated as a per-cycle property. This covers bounces that end early, runs that are one tick too short, and highs outside the window. Only the bench scenarios can show these, by comparing against a model of window phases and synchroniser delay.

// File: rtl/event_watch.sv
module event_watch #(
  parameter int TICK_HZ = 1024,
  parameter int SETTLE  = 8,
  parameter int WIN     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate,
  input  logic [1:0] filt,
  input  logic       pu_off,
  input  logic       bat_dis,
  input  logic       halt_en,
  input  logic       on_batt,
  input  logic       clr,
  input  logic       ev_in,
  output logic       pu_en,
  output logic       det_n,
  output logic       halt_req,
  output logic       ev_flag
);
  localparam int PH_W = $clog2(TICK_HZ * 4);
  localparam logic [PH_W-1:0] LAST_2HZ = PH_W'(TICK_HZ / 2 - 1);
  localparam logic [PH_W-1:0] LAST_1HZ = PH_W'(TICK_HZ - 1);
  localparam logic [PH_W-1:0] LAST_QHZ = PH_W'(TICK_HZ * 4 - 1);
  localparam logic [PH_W-1:0] F_SHORT  = PH_W'(TICK_HZ / 256);
  localparam logic [PH_W-1:0] F_MID    = PH_W'(TICK_HZ / 64);
  localparam logic [PH_W-1:0] F_LONG   = PH_W'(TICK_HZ / 32);
  localparam logic [PH_W-1:0] SET_V    = PH_W'(SETTLE);
  localparam logic [PH_W-1:0] WIN_V    = PH_W'(WIN);

  logic [1:0]      sync;
  logic [PH_W-1:0] ph, per_last, need, eval_hi, pu_hi;
  logic            run, good, hit, cont;

  wire in_s = sync[1];
  wire cont_mode = (rate == 2'd0);

  always_comb begin
    case (rate)
      2'd1:    per_last = LAST_2HZ;
      2'd2:    per_last = LAST_1HZ;
      default: per_last = LAST_QHZ;
    endcase
    case (filt)
      2'd1:    need = F_SHORT;
      2'd2:    need = F_MID;
      2'd3:    need = F_LONG;
      default: need = PH_W'(1);
    endcase
  end

  assign eval_hi = SET_V + need - PH_W'(1);
  assign pu_hi   = (SET_V + need > WIN_V) ? SET_V + need : WIN_V;
  assign good    = (ph >= SET_V) && (ph <= eval_hi) && in_s && (ph == SET_V || run);
  assign cont    = cont_mode && in_s;
  assign hit     = en && (cont || (!cont_mode && good && ph == eval_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b00;
      ph      <= '0;
      run     <= 1'b0;
      ev_flag <= 1'b0;
    end else begin
      sync <= {sync[0], ev_in};
      run  <= good;
      if (!en || cont_mode || ph >= per_last) ph <= '0;
      else ph <= ph + PH_W'(1);
      if (hit) ev_flag <= 1'b1;
      else if (clr) ev_flag <= 1'b0;
    end
  end

  assign pu_en    = en && !pu_off && (cont_mode || ph < pu_hi);
  assign det_n    = !(ev_flag && !(on_batt && bat_dis));
  assign halt_req = ev_flag && halt_en;

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag && !clr |=> ev_flag);
  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !ev_flag |=> !ev_flag);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !en |=> !ev_flag);
  // R7
  batt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_batt && bat_dis |-> det_n);
  // R6
  pu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pu_en);
  // R2
  sample_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_flag) && $past(rate) != 2'd0 |-> $past(ph) == $past(eval_hi));
endmodule

// File: tb/event_watch_bench.sv
module event_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 20240611;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, pu_off = 0, bat_dis = 0, halt_en = 0, on_batt = 0, clr = 0, ev_in = 0;
  logic [1:0] rate = 0, filt = 0;
  logic pu_en, det_n, halt_req, ev_flag;
  int tests = 0, fails = 0;
  bit done = 0;

  event_watch u_event_watch (
    .clk(clk), .rst_n(rst_n), .en(en), .rate(rate), .filt(filt), .pu_off(pu_off),
    .bat_dis(bat_dis), .halt_en(halt_en), .on_batt(on_batt), .clr(clr), .ev_in(ev_in),
    .pu_en(pu_en), .det_n(det_n), .halt_req(halt_req), .ev_flag(ev_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int per_of(int r);
    return (r == 1) ? 512 : (r == 2) ? 1024 : (r == 3) ? 4096 : 1;
  endfunction

  function automatic int need_of(int f);
    return (f == 1) ? 4 : (f == 2) ? 16 : (f == 3) ? 32 : 1;
  endfunction

  function automatic bit raw_at(int c, int ps, int pl);
    return (c >= ps) && (c < ps + pl);
  endfunction

  function automatic bit exp_flag(int r, int f, int ps, int pl, int n, bit on);
    int p = per_of(r);
    int q = need_of(f);
    if (!on) return 0;
    if (r == 0) begin
      for (int c = 0; c <= n - 3; c++) if (raw_at(c, ps, pl)) return 1;
      return 0;
    end
    for (int k = 0; k * p + 8 + q - 1 <= n - 1; k++) begin
      bit all = 1;
      for (int i = 0; i < q; i++) if (!raw_at(k * p + 6 + i, ps, pl)) all = 0;
      if (all) return 1;
    end
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(int r, int f, int ps, int pl, int n, bit on,
                          bit puo, bit bat, bit bd, bit he);
    bit ef, ep;
    int pw;
    @(negedge clk);
    en = 0; ev_in = 0; rate = 2'(r); filt = 2'(f);
    pu_off = puo; on_batt = bat; bat_dis = bd; halt_en = he;
    repeat (3) @(negedge clk);
    for (int c = 0; c < n; c++) begin
      en = on;
      ev_in = raw_at(c, ps, pl);
      @(negedge clk);
    end
    ef = exp_flag(r, f, ps, pl, n, on);
    pw = (8 + need_of(f) > 15) ? 8 + need_of(f) : 15;
    ep = on && !puo && (r == 0 || (n % per_of(r)) < pw);
    chk(r == 0 ? "R3 flag" : (f == 0 ? "R1 flag" : "R2 flag"), ev_flag, ef);
    chk(on ? "R8 pull-up" : "R6 pull-up", pu_en, ep);
    chk("R7 det_n", det_n, !(ef && !(bat && bd)));
    chk("R9 halt_req", halt_req, ef && he);
    en = 0; ev_in = 0; clr = 1;
    @(negedge clk);
    clr = 0;
    chk("R5 cleared", ev_flag, 0);
    chk("R4 det_n after clear", det_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk("R4 reset flag", ev_flag, 0);
    chk("R4 reset det_n", det_n, 1);
    chk("R9 reset halt", halt_req, 0);
    rst_n = 1;
    // R6: disabled with line high
    run_case(0, 0, 0, 200, 100, 0, 0, 0, 0, 1);
    run_case(1, 0, 0, 900, 600, 0, 0, 0, 0, 1);
    // R1: bounce ends before the evaluation tick, then one covering it
    run_case(1, 0, 3, 3, 40, 1, 0, 0, 0, 1);
    run_case(1, 0, 4, 3, 40, 1, 0, 0, 0, 1);
    // R2: run one tick short, then exact length
    run_case(1, 1, 6, 3, 40, 1, 0, 0, 0, 0);
    run_case(1, 1, 6, 4, 40, 1, 0, 0, 0, 0);
    run_case(2, 3, 6, 31, 60, 1, 0, 0, 0, 0);
    run_case(2, 3, 6, 32, 60, 1, 0, 0, 0, 0);
    // R3: filter ignored, single tick pulse
    run_case(0, 3, 10, 1, 20, 1, 0, 0, 0, 1);
    // R7: battery silence with an event
    run_case(0, 0, 2, 5, 30, 1, 0, 1, 1, 1);
    // R8: pull-up forced off, window edge in a filtered mode
    run_case(1, 2, 0, 0, 23, 1, 0, 0, 0, 0);
    run_case(1, 2, 0, 0, 24, 1, 0, 0, 0, 0);
    run_case(0, 0, 0, 0, 30, 1, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      int r = $urandom_range(0, 3);
      int f = $urandom_range(0, 3);
      int n = (r == 3) ? $urandom_range(20, 4300) : $urandom_range(20, 1200);
      int ps = $urandom_range(0, n);
      int pl = $urandom_range(0, 1) ? $urandom_range(1, 40) : n;
      run_case(r, f, ps, pl, n, 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule